// File: doc/BRIEF.md
# Chainable Fall-Through FIFO

This block is a synchronous FIFO that shows its oldest word at its outputs without waiting for a read request. It has two active-low handshake flags. `outReadyN` low means a valid word sits on `rdData`. `inReadyN` low means at least one slot is free. Because the flags are active low, one stage's output flag can drive the next stage's write enable. In the same way, the next stage's input flag can drive this stage's read enable. A chain of stages therefore needs no glue logic.

The top wrapper builds a chain of `STAGES` identical stages. All stages run on one clock, which serves as the write, read and transfer clock. The chain holds `STAGES × STAGE_DEPTH` words. A word written into an empty chain moves forward on its own until it reaches the last stage. A slot freed at the tail of a full chain moves backward until it reaches the head.

Each stage has fixed flag latencies:
- A word accepted into an empty stage raises that stage's data-valid indication three clock edges later.
- A word taken from a full stage frees a slot two edges later.

Top module: `cfifo_chain`

## Requirements
- R1: While `rst` (active high, synchronous) is asserted, and in the first cycle after it is released, `outReadyN` is 1 and `inReadyN` is 0.
- R2: With `rdEnN` held at 1, the first word written into an empty chain appears on `rdData` with `outReadyN` at 0, and it stays there unchanged.
- R3: A word accepted at clock edge e into an empty chain of N stages drives `outReadyN` to 0 right after edge e + (N−1)·4 + 3, and not before.
- R4: Suppose a burst of words is written on consecutive edges into an empty chain while `rdEnN` is held at 0. The words then leave the chain on consecutive cycles in write order, the first at the latency of R3. `outReadyN` returns to 1 one cycle after the last word.
- R5: In a full chain of N stages, a single read accepted at edge e drives `inReadyN` to 0 right after edge e + (N−1)·3 + 2.
- R6: Under continuous writes with no reads, a chain accepts exactly `STAGES × STAGE_DEPTH` words before `inReadyN` stays at 1.
- R7: A write presented (`wrEnN` = 0) while `inReadyN` = 1 is ignored. It neither adds a word nor changes any stored word.
- R8: A read presented (`rdEnN` = 0) while `outReadyN` = 1 is ignored. The chain stays empty, and a word written later is still delivered intact.
- R9: Under any pattern of write and read enables, the words read out match the accepted words in order. `outReadyN` is never 0 when no accepted word remains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared write/read/transfer clock |
| rst | input | 1 | Synchronous active-high reset |
| wrEnN | input | 1 | Active-low write enable of the first stage |
| wrData | input | WIDTH | Write data of the first stage |
| inReadyN | output | 1 | Active-low: first stage has a free slot |
| rdEnN | input | 1 | Active-low read enable of the last stage |
| rdData | output | WIDTH | Head word of the last stage |
| outReadyN | output | 1 | Active-low: valid word on `rdData` |

## Verification
Three chains of one, two and three stages are driven with the same stimulus:
- A single write into an empty chain exposes the forward latency for each length. A stage that adds or drops a pipeline register shows up as a wrong cycle count.
- A back-to-back burst with reads held on separates correct streaming from a design that stalls between words or reorders them.
- Writing far past capacity, then taking one word out, measures the depth of each chain and the backward latency of the freed slot. Draining afterwards reveals any word damaged by an ignored write.
- A long run with random enables is compared against an ordered model to catch order and underflow errors.

// File: rtl/cfifo_pkg.sv
`timescale 1ns/1ps
package cfifo_pkg;
  // Strobes from a stage's control to its datapath
  typedef struct packed {
    logic push;   // store wrData at the write pointer
    logic fetch;  // move the word at the read pointer into the head register
  } stage_strobe_t;
endpackage

// File: rtl/cfifo_ctrl.sv
`timescale 1ns/1ps
module cfifo_ctrl
  import cfifo_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wrEnN,
  input  logic          rdEnN,
  output stage_strobe_t strobe,
  output logic          inReadyN,
  output logic          outReadyN
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_LEVEL = CW'(DEPTH);

  logic [CW-1:0] fillCount;   // write-side view: slots in use
  logic [CW-1:0] availCount;  // read-side view: words waiting behind the head
  logic [1:0]    pushDly;     // delays a write's visibility to the read side
  logic [1:0]    popDly;      // delays a read's slot release to the write side
  logic          headValid;
  logic          wrAccept;
  logic          rdAccept;
  logic          fetch;

  assign wrAccept = !wrEnN && (fillCount != FULL_LEVEL);
  assign rdAccept = !rdEnN && headValid;
  assign fetch    = (availCount != '0) && (!headValid || rdAccept);

  always_ff @(posedge clk) begin
    if (rst) begin
      fillCount  <= '0;
      availCount <= '0;
      pushDly    <= '0;
      popDly     <= '0;
      headValid  <= 1'b0;
    end else begin
      pushDly    <= {pushDly[0], wrAccept};
      popDly     <= {popDly[0], rdAccept};
      fillCount  <= fillCount + CW'(wrAccept) - CW'(popDly[1]);
      availCount <= availCount + CW'(pushDly[1]) - CW'(fetch);
      headValid  <= fetch || (headValid && !rdAccept);
    end
  end

  assign strobe.push  = wrAccept;
  assign strobe.fetch = fetch;
  assign inReadyN     = (fillCount == FULL_LEVEL);
  assign outReadyN    = !headValid;
endmodule

// File: rtl/cfifo_data.sv
`timescale 1ns/1ps
module cfifo_data
  import cfifo_pkg::*;
#(
  parameter int WIDTH = 18,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  stage_strobe_t    strobe,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] rdData
);
  localparam int PW = $clog2(DEPTH);
  localparam logic [PW-1:0] LAST_SLOT = PW'(DEPTH - 1);

  logic [WIDTH-1:0] store [DEPTH];
  logic [PW-1:0]    wrPtr;
  logic [PW-1:0]    rdPtr;
  logic [WIDTH-1:0] headReg;

  always_ff @(posedge clk) begin
    if (strobe.push) store[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      headReg <= '0;
    end else begin
      if (strobe.push) wrPtr <= (wrPtr == LAST_SLOT) ? '0 : wrPtr + 1'b1;
      if (strobe.fetch) begin
        headReg <= store[rdPtr];
        rdPtr   <= (rdPtr == LAST_SLOT) ? '0 : rdPtr + 1'b1;
      end
    end
  end

  assign rdData = headReg;
endmodule

// File: rtl/cfifo_stage.sv
`timescale 1ns/1ps
module cfifo_stage
  import cfifo_pkg::*;
#(
  parameter int WIDTH = 18,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wrEnN,
  input  logic [WIDTH-1:0] wrData,
  output logic             inReadyN,
  input  logic             rdEnN,
  output logic [WIDTH-1:0] rdData,
  output logic             outReadyN
);
  stage_strobe_t strobe;

  cfifo_ctrl #(.DEPTH(DEPTH)) ctrl (
    .clk(clk), .rst(rst), .wrEnN(wrEnN), .rdEnN(rdEnN),
    .strobe(strobe), .inReadyN(inReadyN), .outReadyN(outReadyN)
  );

  cfifo_data #(.WIDTH(WIDTH), .DEPTH(DEPTH)) data (
    .clk(clk), .rst(rst), .strobe(strobe), .wrData(wrData), .rdData(rdData)
  );
endmodule

// File: rtl/cfifo_chain.sv
`timescale 1ns/1ps
module cfifo_chain #(
  parameter int WIDTH       = 18,
  parameter int STAGE_DEPTH = 16,
  parameter int STAGES      = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wrEnN,
  input  logic [WIDTH-1:0] wrData,
  output logic             inReadyN,
  input  logic             rdEnN,
  output logic [WIDTH-1:0] rdData,
  output logic             outReadyN
);
  // Link k feeds stage k: fwdN/fwdData come from stage k-1 (or the ports),
  // backN[k] is stage k's input flag, read by stage k-1.
  logic             fwdN    [STAGES+1];
  logic [WIDTH-1:0] fwdData [STAGES+1];
  logic             backN   [STAGES+1];

  assign fwdN[0]        = wrEnN;
  assign fwdData[0]     = wrData;
  assign backN[STAGES]  = rdEnN;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    cfifo_stage #(.WIDTH(WIDTH), .DEPTH(STAGE_DEPTH)) stage (
      .clk(clk), .rst(rst),
      .wrEnN(fwdN[i]), .wrData(fwdData[i]), .inReadyN(backN[i]),
      .rdEnN(backN[i+1]), .rdData(fwdData[i+1]), .outReadyN(fwdN[i+1])
    );
  end

  assign inReadyN  = backN[0];
  assign outReadyN = fwdN[STAGES];
  assign rdData    = fwdData[STAGES];
endmodule

// File: rtl/cfifo_chain_checker.sv
`timescale 1ns/1ps
module cfifo_chain_checker #(
  parameter int WIDTH       = 18,
  parameter int STAGE_DEPTH = 16,
  parameter int STAGES      = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             wrEnN,
  input logic             inReadyN,
  input logic             rdEnN,
  input logic [WIDTH-1:0] rdData,
  input logic             outReadyN
);
  localparam int CAP = STAGES * STAGE_DEPTH;
  localparam int OW  = $clog2(CAP + 1) + 1;
  localparam int LAT = (STAGES - 1) * 4 + 3;
  localparam int LW  = $clog2(LAT + 2);

  logic          wrAcc;
  logic          rdAcc;
  logic [OW-1:0] occupancy;
  logic [LW-1:0] sinceFirst;
  logic          seenWrite;

  assign wrAcc = !wrEnN && !inReadyN;
  assign rdAcc = !rdEnN && !outReadyN;

  always_ff @(posedge clk) begin
    if (rst) begin
      occupancy  <= '0;
      sinceFirst <= '0;
      seenWrite  <= 1'b0;
    end else begin
      occupancy <= occupancy + OW'(wrAcc) - OW'(rdAcc);
      if (!seenWrite && wrAcc) begin
        seenWrite  <= 1'b1;
        sinceFirst <= LW'(1);
      end else if (seenWrite && sinceFirst != LW'(LAT + 1)) begin
        sinceFirst <= sinceFirst + 1'b1;
      end
    end
  end

  assert_reset_flags_R1: assert property (@(posedge clk)
    rst |=> (outReadyN && !inReadyN));

  assert_hold_word_R2: assert property (@(posedge clk) disable iff (rst)
    (!outReadyN && rdEnN) |=> (!outReadyN && $stable(rdData)));

  assert_min_latency_R3: assert property (@(posedge clk) disable iff (rst)
    !outReadyN |-> (seenWrite && sinceFirst == LW'(LAT + 1)));

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
    occupancy <= OW'(CAP));

  assert_no_underflow_R9: assert property (@(posedge clk) disable iff (rst)
    !outReadyN |-> (occupancy != '0));
endmodule

bind cfifo_chain cfifo_chain_checker #(
  .WIDTH(WIDTH), .STAGE_DEPTH(STAGE_DEPTH), .STAGES(STAGES)
) chk (
  .clk(clk), .rst(rst), .wrEnN(wrEnN), .inReadyN(inReadyN),
  .rdEnN(rdEnN), .rdData(rdData), .outReadyN(outReadyN)
);

// File: tb/cfifo_chain_test.sv
`timescale 1ns/1ps
module cfifo_chain_test;
  localparam int W = 18;
  localparam int D = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wrEnN = 1'b1;
  logic rdEnN = 1'b1;
  logic [W-1:0] wrData = '0;
  logic irN [1:3];
  logic orN [1:3];
  logic [W-1:0] q [1:3];

  always #2.5 clk = ~clk;

  cfifo_chain #(.WIDTH(W), .STAGE_DEPTH(D), .STAGES(3)) uut (
    .clk(clk), .rst(rst), .wrEnN(wrEnN), .wrData(wrData), .inReadyN(irN[3]),
    .rdEnN(rdEnN), .rdData(q[3]), .outReadyN(orN[3]));
  cfifo_chain #(.WIDTH(W), .STAGE_DEPTH(D), .STAGES(2)) uut2 (
    .clk(clk), .rst(rst), .wrEnN(wrEnN), .wrData(wrData), .inReadyN(irN[2]),
    .rdEnN(rdEnN), .rdData(q[2]), .outReadyN(orN[2]));
  cfifo_chain #(.WIDTH(W), .STAGE_DEPTH(D), .STAGES(1)) uut1 (
    .clk(clk), .rst(rst), .wrEnN(wrEnN), .wrData(wrData), .inReadyN(irN[1]),
    .rdEnN(rdEnN), .rdData(q[1]), .outReadyN(orN[1]));

  int errors = 0;
  int checks = 0;
  bit done = 0;
  logic [W-1:0] model [$];

  task automatic checkEq(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    rst = 1'b1; wrEnN = 1'b1; rdEnN = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int n = 1; n <= 3; n++) begin
      checkEq("R1", "outReadyN after reset", orN[n], 1);
      checkEq("R1", "inReadyN after reset", irN[n], 0);
    end
  endtask

  // Drain uut (3 stages) against the model
  task automatic drainModel(input string req);
    rdEnN = 1'b0;
    for (int k = 0; k < 300 && model.size() > 0; k++) begin
      if (!orN[3]) checkEq(req, "drained word", q[3], model.pop_front());
      @(posedge clk); @(negedge clk);
    end
    rdEnN = 1'b1;
    checkEq(req, "model empty after drain", model.size(), 0);
    repeat (4) begin @(posedge clk); @(negedge clk); end
    checkEq(req, "outReadyN after drain", orN[3], 1);
  endtask

  task automatic testFallThrough();
    int first [1:3];
    doReset();
    rdEnN = 1'b0;  // R8: reads while empty
    repeat (6) begin
      @(posedge clk); @(negedge clk);
      for (int n = 1; n <= 3; n++) checkEq("R8", "outReadyN with read on empty", orN[n], 1);
    end
    rdEnN = 1'b1;
    wrEnN = 1'b0; wrData = 18'h2A5C3;
    @(posedge clk); @(negedge clk);
    wrEnN = 1'b1;
    for (int n = 1; n <= 3; n++) first[n] = 0;
    for (int k = 1; k <= 20; k++) begin
      @(posedge clk); @(negedge clk);
      for (int n = 1; n <= 3; n++) if (first[n] == 0 && !orN[n]) first[n] = k;
    end
    for (int n = 1; n <= 3; n++) begin
      checkEq("R3", "empty-chain latency", first[n], (n - 1) * 4 + 3);
      checkEq("R2", "head word without read", q[n], 18'h2A5C3);
      checkEq("R2", "head still valid", orN[n], 0);
    end
  endtask

  task automatic testStream();
    doReset();
    rdEnN = 1'b0;
    for (int k = 0; k <= 22; k++) begin
      wrEnN = (k < 5) ? 1'b0 : 1'b1;
      wrData = W'(18'h100 + k);
      @(posedge clk); @(negedge clk);
      for (int n = 1; n <= 3; n++) begin
        int lat = (n - 1) * 4 + 3;
        if (k >= lat && k < lat + 5) begin
          checkEq("R4", "stream valid", orN[n], 0);
          checkEq("R4", "stream word", q[n], 18'h100 + k - lat);
        end else if (k == lat + 5) begin
          checkEq("R4", "stream ended", orN[n], 1);
        end
      end
    end
    rdEnN = 1'b1;
  endtask

  task automatic testFullChain();
    int acc [1:3];
    int first [1:3];
    doReset();
    model.delete();
    for (int n = 1; n <= 3; n++) begin acc[n] = 0; first[n] = 0; end
    for (int k = 0; k < 150; k++) begin
      wrEnN = 1'b0;
      wrData = W'(18'h3000 + k);
      for (int n = 1; n <= 3; n++) if (!irN[n]) acc[n]++;
      if (!irN[3]) model.push_back(wrData);
      @(posedge clk); @(negedge clk);
    end
    wrEnN = 1'b1;
    for (int n = 1; n <= 3; n++) begin
      checkEq("R6", "accepted words", acc[n], n * D);
      checkEq("R7", "inReadyN while full", irN[n], 1);
    end
    checkEq("R7", "head word after ignored writes", q[3], model[0]);
    rdEnN = 1'b0;
    @(posedge clk); @(negedge clk);
    rdEnN = 1'b1;
    void'(model.pop_front());
    for (int k = 1; k <= 20; k++) begin
      @(posedge clk); @(negedge clk);
      for (int n = 1; n <= 3; n++) if (first[n] == 0 && !irN[n]) first[n] = k;
    end
    for (int n = 1; n <= 3; n++)
      checkEq("R5", "full-chain free latency", first[n], (n - 1) * 3 + 2);
    drainModel("R7");
  endtask

  task automatic testRandom();
    doReset();
    model.delete();
    for (int k = 0; k < 800; k++) begin
      wrEnN = ($urandom_range(9) >= 6);
      rdEnN = ($urandom_range(9) >= 5);
      wrData = W'($urandom);
      if (!rdEnN && !orN[3]) begin
        if (model.size() == 0) checkEq("R9", "valid with empty model", 1, 0);
        else checkEq("R9", "random read word", q[3], model.pop_front());
      end
      if (!wrEnN && !irN[3]) model.push_back(wrData);
      @(posedge clk); @(negedge clk);
    end
    wrEnN = 1'b1;
    drainModel("R9");
  endtask

  initial begin
    @(negedge clk);
    testFallThrough();
    testStream();
    testFullChain();
    testRandom();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #900000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule